// File: doc/BRIEF.md
# Sensor Sample Register Readout Unit

This block is the read side of a three-axis sensor's register bank, placed behind a byte-wide serial register interface. It keeps the newest 14-bit X, Y and Z samples and, when a nonzero FIFO mode is selected, also queues up to 32 past X/Y/Z triplets. The bus side issues one byte read per `rdReq`. It either loads a new address or continues from an internal pointer that advances after every read. An optional fast mode skips the low-byte addresses during this auto-increment.

Each axis is split into a high byte (sample bits 13..6) and a low byte (sample bits 5..0 placed in bits 7..2, with bits 1..0 zero). A read of a high byte copies the matching low byte into a shadow register, and every low-byte address returns that shadow. As a result, a high/low byte pair always belongs to one sample. When the FIFO is enabled, address 0 becomes a status byte and address 1 walks through the bytes of the oldest queued triplet. That triplet is popped once its last byte has been read.

Top module: `sensor_readout`

## Requirements
- R1: After reset, rdValid is 0, the read pointer is 0, the FIFO is empty and the overflow flag is clear.
- R2: A read request at address A (rdAddr when rdLoad is 1, otherwise the internal pointer) returns its byte on rdData with rdValid high exactly one cycle later.
- R3: With fifoMode 0, address 0 reads as zero, and addresses 1, 3 and 5 return bits 13..6 of the latest X, Y and Z sample respectively.
- R4: With fifoMode 0, a read of address 1, 3 or 5 latches that axis's bits 5..0 into bits 7..2 of a shadow byte (bits 1..0 zero), and addresses 2, 4 and 6 always return the shadow. A sample arriving in the same cycle as the high-byte read, or later, does not alter the latched pair.
- R5: With fastRead 0, the pointer advances A to A+1 after each read, and addresses 6 and 7 wrap to 0. Address 7 reads as zero.
- R6: With fastRead 1, the auto-increment sequence is 0, 1, 3, 5, 0. A read of address 2 or 4 advances to A+1, and a read of address 6 advances to 0.
- R7: With fifoMode nonzero, address 0 returns {overflow, watermark, count[5:0]}, where watermark is 1 when count is at least wmLevel.
- R8: With fifoMode nonzero, every sampleValid appends the triplet if fewer than 32 entries are held. Otherwise the triplet is dropped and overflow is set. Reading the status clears overflow after returning it, and a set in the same cycle takes priority over the clear.
- R9: With fifoMode nonzero, address 1 returns the head entry's bytes in the order X high, X low, Y high, Y low, Z high, Z low (only the three high bytes when fastRead is 1). The pointer stays at 1, the entry is popped after its last byte, and addresses 2 to 7 read as zero.
- R10: A read of address 1 with fifoMode nonzero and an empty FIFO returns zero and does not advance within an entry.
- R11: With fifoMode 0, the FIFO is emptied and overflow cleared. The latest-sample registers update on every sampleValid in every mode.
- R12: A pop and an accepted push in the same cycle leave the count unchanged. Fullness is judged on the count before that cycle's pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | New X/Y/Z sample present this cycle |
| sampleX | input | 14 | X sample, two's complement |
| sampleY | input | 14 | Y sample, two's complement |
| sampleZ | input | 14 | Z sample, two's complement |
| fifoMode | input | 2 | 0 disables the FIFO, any other value enables it |
| fastRead | input | 1 | Skip low-byte addresses on auto-increment |
| wmLevel | input | 6 | Watermark threshold compared against the count |
| rdReq | input | 1 | One byte read request |
| rdLoad | input | 1 | Use rdAddr for this read instead of the pointer |
| rdAddr | input | 3 | Read address when rdLoad is 1 |
| rdData | output | 8 | Returned byte |
| rdValid | output | 1 | rdData holds the answer to last cycle's request |

## Verification
Two pairs of events can fall in the same cycle. The first is a status read that clears overflow together with a sample that overflows a full FIFO. The second is the pop caused by reading an entry's last byte together with an accepted push. The bench drives sampleValid in the very cycle of the status read, or of the final Z low-byte read. It then judges the outcome through later status reads: overflow must remain set in the first case, and the count must be unchanged in the second. A new sample landing in the same cycle as a high-byte read is also provoked, and the following low-byte read must still return the old sample's bits.

// File: rtl/sensor_readout_pkg.sv
package sensor_readout_pkg;

  localparam int SAMPLE_W = 14;
  localparam int AXES     = 3;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_STATUS,
    SEL_MSB,
    SEL_LSB,
    SEL_FIFO
  } rdsel_e;

  typedef struct packed {
    logic       rdFire;
    rdsel_e     sel;
    logic [1:0] axis;
    logic [2:0] fifoByte;
    logic       popFifo;
    logic       clrOvf;
    logic       latchLsb;
  } strobe_t;

  function automatic logic [7:0] hiByte(input logic [SAMPLE_W-1:0] s);
    return s[SAMPLE_W-1 -: 8];
  endfunction

  function automatic logic [7:0] loByte(input logic [SAMPLE_W-1:0] s);
    return {s[SAMPLE_W-9:0], 2'b00};
  endfunction

endpackage

// File: rtl/sensor_readout_ctrl.sv
module sensor_readout_ctrl
  import sensor_readout_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       rdLoad,
  input  logic [2:0] rdAddr,
  input  logic       fastRead,
  input  logic       fifoOn,
  input  logic       fifoEmpty,
  output strobe_t    strb
);

  localparam logic [2:0] LAST_DATA = 3'd6;

  logic [2:0] ptr;
  logic [2:0] ptrNext;
  logic [2:0] effAddr;
  logic [2:0] idx;
  logic       lastByte;

  assign effAddr  = rdLoad ? rdAddr : ptr;
  assign lastByte = (idx == 3'd5) || (fastRead && (idx >= 3'd4));

  always_comb begin
    strb          = '0;
    strb.rdFire   = rdReq;
    strb.sel      = SEL_ZERO;
    strb.axis     = 2'((effAddr - 3'd1) >> 1);
    strb.fifoByte = idx;
    if (fifoOn) begin
      if (effAddr == 3'd0) begin
        strb.sel    = SEL_STATUS;
        strb.clrOvf = rdReq;
      end else if (effAddr == 3'd1 && !fifoEmpty) begin
        strb.sel     = SEL_FIFO;
        strb.popFifo = rdReq && lastByte;
      end
    end else begin
      unique case (effAddr)
        3'd1, 3'd3, 3'd5: begin
          strb.sel      = SEL_MSB;
          strb.latchLsb = rdReq;
        end
        3'd2, 3'd4, 3'd6: strb.sel = SEL_LSB;
        default:          strb.sel = SEL_ZERO;
      endcase
    end
  end

  always_comb begin
    if (fifoOn && effAddr == 3'd1)
      ptrNext = 3'd1;
    else if (effAddr >= LAST_DATA)
      ptrNext = 3'd0;
    else if (fastRead && effAddr[0])
      ptrNext = (effAddr == 3'd5) ? 3'd0 : effAddr + 3'd2;
    else
      ptrNext = effAddr + 3'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      idx <= '0;
    end else begin
      if (rdReq)
        ptr <= ptrNext;
      if (!fifoOn)
        idx <= '0;
      else if (rdReq && effAddr == 3'd1 && !fifoEmpty)
        idx <= lastByte ? 3'd0 : idx + (fastRead ? 3'd2 : 3'd1);
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST_DATA); // R5

  AST_FAST_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdLoad && fastRead && !fifoOn && (ptr == 3'd0 || ptr[0]))
      |=> (ptr == 3'd0 || ptr[0])); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    idx <= 3'd5); // R9

  AST_FIFO_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && fifoOn && effAddr == 3'd1) |=> ptr == 3'd1); // R9

endmodule

// File: rtl/sensor_readout_dp.sv
module sensor_readout_dp
  import sensor_readout_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleX,
  input  logic [SAMPLE_W-1:0] sampleY,
  input  logic [SAMPLE_W-1:0] sampleZ,
  input  logic                fifoOn,
  input  logic [5:0]          wmLevel,
  input  strobe_t             strb,
  output logic                fifoEmpty,
  output logic [7:0]          rdData,
  output logic                rdValid
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  typedef logic [AXES-1:0][SAMPLE_W-1:0] triplet_t;

  triplet_t      sampleVec;
  triplet_t      cur;
  triplet_t      mem [DEPTH];
  triplet_t      head;
  logic [7:0]    shadow;
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          ovf;
  logic          full, doPush, doPop, wmHit;
  logic [7:0]    statusByte, fifoByteVal, msbVal, muxOut;

  assign sampleVec = {sampleZ, sampleY, sampleX};

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cur[g] <= '0;
      else if (sampleValid)
        cur[g] <= sampleVec[g];
    end
  end

  function automatic logic [SAMPLE_W-1:0] pickAxis(input triplet_t t,
                                                   input logic [1:0] a);
    case (a)
      2'd0:    return t[0];
      2'd1:    return t[1];
      default: return t[2];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shadow <= '0;
    else if (strb.latchLsb)
      shadow <= loByte(pickAxis(cur, strb.axis));
  end

  assign full      = (count == FULL_CNT);
  assign fifoEmpty = (count == '0);
  assign doPush    = sampleValid && fifoOn && !full;
  assign doPop     = strb.popFifo && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (doPush)
      mem[wrPtr] <= sampleVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else if (!fifoOn) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush)
        wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + AW'(1);
      if (doPop)
        rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + AW'(1);
      if (doPush && !doPop)
        count <= count + CW'(1);
      else if (doPop && !doPush)
        count <= count - CW'(1);
      if (sampleValid && full)
        ovf <= 1'b1;
      else if (strb.clrOvf)
        ovf <= 1'b0;
    end
  end

  assign head        = mem[rdPtr];
  assign wmHit       = (32'(count) >= 32'(wmLevel));
  assign statusByte  = {ovf, wmHit, 6'(count)};
  assign msbVal      = hiByte(pickAxis(cur, strb.axis));
  assign fifoByteVal = strb.fifoByte[0]
                       ? loByte(pickAxis(head, strb.fifoByte[2:1]))
                       : hiByte(pickAxis(head, strb.fifoByte[2:1]));

  always_comb begin
    unique case (strb.sel)
      SEL_STATUS: muxOut = statusByte;
      SEL_MSB:    muxOut = msbVal;
      SEL_LSB:    muxOut = shadow;
      SEL_FIFO:   muxOut = fifoByteVal;
      default:    muxOut = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdFire;
      if (strb.rdFire)
        rdData <= muxOut;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdFire |=> rdValid); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R8

  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOn && sampleValid && full) |=> ovf); // R8

  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOn && doPop && !sampleValid) |=> count == $past(count) - CW'(1)); // R9

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !fifoOn |=> (count == '0 && !ovf)); // R11

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOn && doPush && doPop) |=> $stable(count)); // R12

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchLsb |=> $stable(shadow)); // R4

endmodule

// File: rtl/sensor_readout.sv
module sensor_readout
  import sensor_readout_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [13:0] sampleX,
  input  logic [13:0] sampleY,
  input  logic [13:0] sampleZ,
  input  logic [1:0]  fifoMode,
  input  logic        fastRead,
  input  logic [5:0]  wmLevel,
  input  logic        rdReq,
  input  logic        rdLoad,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  output logic        rdValid
);

  strobe_t strb;
  logic    fifoOn;
  logic    fifoEmpty;

  assign fifoOn = (fifoMode != 2'b00);

  sensor_readout_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdReq     (rdReq),
    .rdLoad    (rdLoad),
    .rdAddr    (rdAddr),
    .fastRead  (fastRead),
    .fifoOn    (fifoOn),
    .fifoEmpty (fifoEmpty),
    .strb      (strb)
  );

  sensor_readout_dp #(.DEPTH(DEPTH)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleX     (sampleX),
    .sampleY     (sampleY),
    .sampleZ     (sampleZ),
    .fifoOn      (fifoOn),
    .wmLevel     (wmLevel),
    .strb        (strb),
    .fifoEmpty   (fifoEmpty),
    .rdData      (rdData),
    .rdValid     (rdValid)
  );

endmodule

// File: tb/test_sensor_readout.sv
`timescale 1ns/1ps
module test_sensor_readout;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [13:0] sampleX = '0, sampleY = '0, sampleZ = '0;
  logic [1:0]  fifoMode = 2'b00;
  logic        fastRead = 1'b0;
  logic [5:0]  wmLevel = 6'd0;
  logic        rdReq = 1'b0;
  logic        rdLoad = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        rdValid;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  sensor_readout i_sensor_readout (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .fifoMode(fifoMode), .fastRead(fastRead), .wmLevel(wmLevel),
    .rdReq(rdReq), .rdLoad(rdLoad), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [7:0] hb(input logic [13:0] s);
    return s[13:6];
  endfunction
  function automatic logic [7:0] lb(input logic [13:0] s);
    return {s[5:0], 2'b00};
  endfunction
  function automatic logic [13:0] genX(input int i); return 14'((i << 6) | i); endfunction
  function automatic logic [13:0] genY(input int i); return 14'((i + 1) << 6); endfunction
  function automatic logic [13:0] genZ(input int i); return 14'(((i + 2) << 6) | 5); endfunction

  // monitor: pop expected bytes as the design returns them
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R2 unexpected rdValid, actual %02h expected none", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          testsFailed++;
          $display("FAIL %s: actual %02h expected %02h", t, rdData, e);
        end
      end
    end
  end

  // driver: one byte read, optionally with a sample in the same cycle
  task automatic rd(input bit load, input logic [2:0] addr, input logic [7:0] exp,
                    input string tag, input bit withSample = 0,
                    input logic [13:0] sx = '0, input logic [13:0] sy = '0,
                    input logic [13:0] sz = '0);
    @(negedge clk);
    rdReq = 1'b1; rdLoad = load; rdAddr = addr;
    if (withSample) begin
      sampleValid = 1'b1; sampleX = sx; sampleY = sy; sampleZ = sz;
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdReq = 1'b0; rdLoad = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic push(input logic [13:0] sx, input logic [13:0] sy, input logic [13:0] sz);
    @(negedge clk);
    sampleValid = 1'b1; sampleX = sx; sampleY = sy; sampleZ = sz;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [13:0] ax, ay, az, bx, by, bz, cx, cy, cz;
    ax = 14'h2A5C; ay = 14'h0F31; az = 14'h3FFF;
    bx = 14'h1357; by = 14'h2468; bz = 14'h0ACE;
    cx = 14'h3001; cy = 14'h0FC2; cz = 14'h1F3B;

    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testsRun++;
    if (rdValid !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1 rdValid after reset: actual %0b expected 0", rdValid);
    end
    // R1: pointer at 0, empty FIFO, overflow clear -> status 0x40 with wmLevel 0
    fifoMode = 2'b01; wmLevel = 6'd0;
    rd(0, 3'd0, 8'h40, "R1 reset status via pointer");
    fifoMode = 2'b00;
    idle(1);

    // R3 / R5: full burst in direct mode
    push(ax, ay, az);
    rd(1, 3'd0, 8'h00, "R3 addr0 direct");
    rd(0, 3'd0, hb(ax), "R3 X msb");
    rd(0, 3'd0, lb(ax), "R4 X lsb");
    rd(0, 3'd0, hb(ay), "R3 Y msb");
    rd(0, 3'd0, lb(ay), "R4 Y lsb");
    rd(0, 3'd0, hb(az), "R3 Z msb");
    rd(0, 3'd0, lb(az), "R4 Z lsb");
    rd(0, 3'd0, 8'h00, "R5 wrap to addr0");
    rd(1, 3'd7, 8'h00, "R5 addr7 zero");
    rd(0, 3'd0, 8'h00, "R5 addr7 wraps to 0");

    // R6: fast read burst
    fastRead = 1'b1;
    rd(1, 3'd0, 8'h00, "R6 fast status");
    rd(0, 3'd0, hb(ax), "R6 fast X msb");
    rd(0, 3'd0, hb(ay), "R6 fast Y msb");
    rd(0, 3'd0, hb(az), "R6 fast Z msb");
    rd(0, 3'd0, 8'h00, "R6 fast wrap");
    rd(1, 3'd4, lb(az), "R6 fast from lsb addr");
    rd(0, 3'd0, hb(az), "R6 lsb addr advances by one");
    fastRead = 1'b0;

    // R4: coherency across a new sample
    rd(1, 3'd1, hb(ax), "R4 X msb before new sample");
    push(bx, by, bz);
    rd(0, 3'd0, lb(ax), "R4 X lsb from old sample");
    rd(1, 3'd2, lb(ax), "R4 random lsb read returns shadow");
    rd(1, 3'd3, hb(by), "R4 Y msb new sample");
    rd(1, 3'd2, lb(by), "R4 lsb returns latest latched");
    // sample in same cycle as msb read
    rd(1, 3'd5, hb(bz), "R4 Z msb with same-cycle sample", 1, cx, cy, cz);
    rd(0, 3'd0, lb(bz), "R4 Z lsb old sample");
    rd(1, 3'd5, hb(cz), "R4 Z msb newest");
    rd(0, 3'd0, lb(cz), "R4 Z lsb newest");

    // R7 / R9: FIFO mode basic
    fifoMode = 2'b01; wmLevel = 6'd3;
    idle(1);
    rd(1, 3'd0, 8'h00, "R7 empty status");
    push(genX(50), genY(50), genZ(50));
    push(genX(51), genY(51), genZ(51));
    push(genX(52), genY(52), genZ(52));
    rd(1, 3'd0, 8'h43, "R7 status count3 watermark");
    rd(0, 3'd0, hb(genX(50)), "R9 head X msb");
    rd(0, 3'd0, lb(genX(50)), "R9 head X lsb");
    rd(0, 3'd0, hb(genY(50)), "R9 head Y msb");
    rd(0, 3'd0, lb(genY(50)), "R9 head Y lsb");
    rd(0, 3'd0, hb(genZ(50)), "R9 head Z msb");
    rd(0, 3'd0, lb(genZ(50)), "R9 head Z lsb");
    rd(1, 3'd0, 8'h02, "R9 popped after last byte");
    rd(1, 3'd2, 8'h00, "R9 addr2 zero in FIFO mode");
    rd(1, 3'd5, 8'h00, "R9 addr5 zero in FIFO mode");
    fastRead = 1'b1;
    rd(1, 3'd1, hb(genX(51)), "R9 fast X msb");
    rd(0, 3'd0, hb(genY(51)), "R9 fast Y msb");
    rd(0, 3'd0, hb(genZ(51)), "R9 fast Z msb");
    fastRead = 1'b0;
    rd(1, 3'd0, 8'h01, "R9 fast pop after Z msb");
    rd(1, 3'd1, hb(genX(52)), "R9 last X msb");
    rd(0, 3'd0, lb(genX(52)), "R9 last X lsb");
    rd(0, 3'd0, hb(genY(52)), "R9 last Y msb");
    rd(0, 3'd0, lb(genY(52)), "R9 last Y lsb");
    rd(0, 3'd0, hb(genZ(52)), "R9 last Z msb");
    rd(0, 3'd0, lb(genZ(52)), "R9 last Z lsb");
    rd(1, 3'd1, 8'h00, "R10 empty FIFO reads zero");
    rd(1, 3'd0, 8'h00, "R10 still empty");

    // R8: overflow
    wmLevel = 6'd32;
    for (int i = 0; i < 33; i++) push(genX(i), genY(i), genZ(i));
    rd(1, 3'd0, 8'hE0, "R8 overflow full watermark");
    rd(1, 3'd0, 8'h60, "R8 overflow cleared by read");
    rd(1, 3'd1, hb(genX(0)), "R8 oldest kept X msb");
    rd(0, 3'd0, lb(genX(0)), "R8 oldest X lsb");
    rd(0, 3'd0, hb(genY(0)), "R8 oldest Y msb");
    rd(0, 3'd0, lb(genY(0)), "R8 oldest Y lsb");
    rd(0, 3'd0, hb(genZ(0)), "R8 oldest Z msb");
    rd(0, 3'd0, lb(genZ(0)), "R8 oldest Z lsb");
    rd(1, 3'd0, 8'h1F, "R8 count 31");

    // R12: push and pop in the same cycle
    rd(1, 3'd1, hb(genX(1)), "R12 entry1 X msb");
    rd(0, 3'd0, lb(genX(1)), "R12 entry1 X lsb");
    rd(0, 3'd0, hb(genY(1)), "R12 entry1 Y msb");
    rd(0, 3'd0, lb(genY(1)), "R12 entry1 Y lsb");
    rd(0, 3'd0, hb(genZ(1)), "R12 entry1 Z msb");
    rd(0, 3'd0, lb(genZ(1)), "R12 entry1 Z lsb with push", 1, genX(40), genY(40), genZ(40));
    rd(1, 3'd0, 8'h1F, "R12 count unchanged");
    push(genX(41), genY(41), genZ(41));
    rd(1, 3'd0, 8'h60, "R8 full again");
    push(genX(42), genY(42), genZ(42));
    rd(1, 3'd0, 8'hE0, "R8 status read with overflow push", 1, genX(43), genY(43), genZ(43));
    rd(1, 3'd0, 8'hE0, "R8 set wins over clear");
    rd(1, 3'd0, 8'h60, "R8 cleared after plain read");

    // R11: disabling the FIFO flushes it; direct registers kept updating
    fifoMode = 2'b00;
    idle(2);
    rd(1, 3'd1, hb(genX(43)), "R11 direct reg tracked samples");
    rd(1, 3'd0, 8'h00, "R11 addr0 zero in direct mode");
    fifoMode = 2'b10;
    idle(1);
    rd(1, 3'd0, 8'h00, "R11 FIFO flushed");

    idle(3);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule